// File: doc/BRIEF.md
# Cartridge ROM Mapper and Bus Arbiter

This block sits between a game console's cartridge connector and a bank of external SRAM chips that hold a ROM image. A small controller fills the SRAM while it owns the memory (load ownership). It then hands the memory to the console, which reads it as cartridge ROM (run ownership). Bus ownership changes only when the controller writes its configuration word with a different run bit. Between the two owners there is an enforced quiet gap in which neither side drives anything.

While the console owns the memory, the block converts the 22-bit console address into a linear image address, using one of two layouts. In the banked layout, address bit 15 is discarded, so each console bank supplies a 32 KB slice of the image. In the flat layout, the console address is used directly. The upper image bits pick one of several SRAM chips. A console read that falls outside the populated image leaves the console data bus undriven. The console write strobe never reaches the SRAM, because running software writes freely into cartridge space.

Top module: `cart_rom_mapper`

## Requirements
- R1: After reset the loader owns the memory: `load_active`=1, `run_active`=0, `cart_doe`=0, `ram_we_n`=1 and every `ram_ce_n` bit is 1.
- R2: Banked layout (map bit 0): linear address = {cart_addr[21:16], cart_addr[14:0]}, with bit 15 ignored. The chip index is linear[18:17]; its `ram_ce_n` bit goes low, and `ram_addr` is linear[16:0]. The read data (`ram_dq_in`) appears on `cart_dout` with `cart_doe`=1. A console read is `cart_cs_n`=0, `cart_rd_n`=0 and `cart_wr_n`=1.
- R3: Flat layout (map bit 1): linear address = cart_addr[21:0], with the same chip and address split as R2.
- R4: A console read whose linear address is 2^19 or above, or any cycle with `cart_cs_n`=1, gives `cart_doe`=0 and all `ram_ce_n` bits 1.
- R5: Whatever the state of `cart_wr_n`, the console never causes `ram_we_n`=0. While `cart_wr_n`=0, `cart_doe` stays 0.
- R6: A write on `cfg_we` with `cfg_run`=1 while the loader owns the memory starts a gap of GAP_CYCLES (default 2) clocks. During the gap `load_active`=`run_active`=0, `cart_doe`=0, `ram_dq_oe`=0 and all `ram_ce_n` bits are 1. After the gap, `run_active`=1. Configuration writes made during the gap are ignored.
- R7: A write with `cfg_run`=0 while the console owns the memory returns ownership to the loader through the same gap.
- R8: Under load ownership, `ld_we`=1 gives `ram_we_n`=0, `ram_dq_oe`=1 and `ram_dq_out`=`ld_wdata`. The selected chip is ld_addr[18:17] and `ram_addr` is ld_addr[16:0]. Console pins have no effect. Under run ownership, loader strobes have no effect.
- R9: The map bit (`cfg_hirom`) is captured only on configuration writes made under load ownership. A write under run ownership leaves the layout unchanged.
- R10: Under load ownership, `ld_re`=1 (with `ld_we`=0) gives `ram_oe_n`=0, and `ld_rdata` returns `ram_dq_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Requested owner: 1 console, 0 loader |
| cfg_hirom | input | 1 | Map select: 0 banked, 1 flat |
| ld_addr | input | 19 | Loader linear image address |
| ld_wdata | input | 8 | Loader write data |
| ld_we | input | 1 | Loader write strobe |
| ld_re | input | 1 | Loader read strobe |
| ld_rdata | output | 8 | Loader read data |
| cart_addr | input | 22 | Console address |
| cart_cs_n | input | 1 | Console ROM select, active low |
| cart_rd_n | input | 1 | Console read strobe, active low |
| cart_wr_n | input | 1 | Console write strobe, active low |
| cart_dout | output | 8 | Data toward console |
| cart_doe | output | 1 | Console data driver enable |
| ram_addr | output | 17 | Address to every SRAM chip |
| ram_ce_n | output | 4 | Per-chip enables, active low |
| ram_oe_n | output | 1 | SRAM output enable, active low |
| ram_we_n | output | 1 | SRAM write enable, active low |
| ram_dq_out | output | 8 | Data toward SRAM |
| ram_dq_oe | output | 1 | SRAM data driver enable |
| ram_dq_in | input | 8 | Data from SRAM |
| load_active | output | 1 | Loader owns the memory |
| run_active | output | 1 | Console owns the memory |

## Verification
The collisions that matter are a console write strobe arriving in the same cycle as a read strobe or a loader strobe, and a configuration write arriving while the other side is still active. The bench holds `cart_wr_n` low together with `cart_rd_n` and with loader writes. It also issues an ownership write while console strobes are still asserted, and writes a new map bit under run ownership. Each case is judged at the pins: `ram_we_n`, `cart_doe`, the chip enables, and whether a later read still decodes with the old layout.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  typedef enum logic [1:0] {
    OWN_LOAD    = 2'd0,
    OWN_TO_RUN  = 2'd1,
    OWN_RUN     = 2'd2,
    OWN_TO_LOAD = 2'd3
  } own_state_e;

endpackage

// File: rtl/cmap_owner_seq.sv
module cmap_owner_seq
  import cart_map_pkg::*;
#(
  parameter int GAP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_run,
  input  logic cfg_hirom,
  output logic load_active,
  output logic run_active,
  output logic hirom
);

  localparam int GAP_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

  logic [1:0]       rst_sync_q;
  logic             rst_q_n;
  own_state_e       state_q, state_d;
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             hirom_q, hirom_d;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    hirom_d = hirom_q;
    unique case (state_q)
      OWN_LOAD: begin
        if (cfg_we) begin
          hirom_d = cfg_hirom;
          if (cfg_run) begin
            state_d = OWN_TO_RUN;
            cnt_d   = '0;
          end
        end
      end
      OWN_TO_RUN: begin
        if (cnt_q == GAP_LAST) state_d = OWN_RUN;
        else                   cnt_d   = cnt_q + GAP_W'(1);
      end
      OWN_RUN: begin
        if (cfg_we && !cfg_run) begin
          state_d = OWN_TO_LOAD;
          cnt_d   = '0;
        end
      end
      OWN_TO_LOAD: begin
        if (cnt_q == GAP_LAST) state_d = OWN_LOAD;
        else                   cnt_d   = cnt_q + GAP_W'(1);
      end
      default: state_d = OWN_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= OWN_LOAD;
      cnt_q   <= '0;
      hirom_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hirom_q <= hirom_d;
    end
  end

  assign load_active = (state_q == OWN_LOAD);
  assign run_active  = (state_q == OWN_RUN);
  assign hirom       = hirom_q;

  AST_RUN_VIA_GAP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == OWN_RUN && $past(state_q) != OWN_RUN) |-> ($past(state_q) == OWN_TO_RUN)); // R6
  AST_LOAD_VIA_GAP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == OWN_LOAD && $past(state_q) != OWN_LOAD) |-> ($past(state_q) == OWN_TO_LOAD)); // R7
  AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(state_q) != OWN_LOAD) |-> $stable(hirom_q)); // R9

endmodule

// File: rtl/cmap_xlate.sv
module cmap_xlate #(
  parameter int CART_AW = 22,
  parameter int IMG_AW  = 19
) (
  input  logic [CART_AW-1:0] cart_addr,
  input  logic               hirom,
  output logic [IMG_AW-1:0]  img_addr,
  output logic               in_range
);

  localparam int LIN_W = CART_AW;

  logic [LIN_W-1:0] lin_banked, lin_flat, lin;

  // banked layout: bit 15 removed, upper bits shift down by one
  assign lin_banked = {1'b0, cart_addr[CART_AW-1:16], cart_addr[14:0]};
  assign lin_flat   = cart_addr;
  assign lin        = hirom ? lin_flat : lin_banked;

  generate
    if (LIN_W > IMG_AW) begin : g_range
      assign in_range = (lin[LIN_W-1:IMG_AW] == '0);
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  assign img_addr = lin[IMG_AW-1:0];

endmodule

// File: rtl/cmap_chip_dec.sv
module cmap_chip_dec #(
  parameter int IMG_AW  = 19,
  parameter int CHIP_AW = 17,
  localparam int NUM_CHIPS = 2 ** (IMG_AW - CHIP_AW)
) (
  input  logic                 en,
  input  logic [IMG_AW-1:0]    lin,
  output logic [NUM_CHIPS-1:0] sel,
  output logic [CHIP_AW-1:0]   low
);

  localparam int IDX_W = IMG_AW - CHIP_AW;

  assign low = lin[CHIP_AW-1:0];

  generate
    if (NUM_CHIPS == 1) begin : g_single
      assign sel[0] = en;
    end else begin : g_multi
      for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_sel
        assign sel[g] = en && (lin[IMG_AW-1:CHIP_AW] == IDX_W'(g));
      end
    end
  endgenerate

endmodule

// File: rtl/cart_rom_mapper.sv
module cart_rom_mapper #(
  parameter int CART_AW    = 22,
  parameter int IMG_AW     = 19,
  parameter int CHIP_AW    = 17,
  parameter int DW         = 8,
  parameter int GAP_CYCLES = 2,
  localparam int NUM_CHIPS = 2 ** (IMG_AW - CHIP_AW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_run,
  input  logic                 cfg_hirom,
  input  logic [IMG_AW-1:0]    ld_addr,
  input  logic [DW-1:0]        ld_wdata,
  input  logic                 ld_we,
  input  logic                 ld_re,
  output logic [DW-1:0]        ld_rdata,
  input  logic [CART_AW-1:0]   cart_addr,
  input  logic                 cart_cs_n,
  input  logic                 cart_rd_n,
  input  logic                 cart_wr_n,
  output logic [DW-1:0]        cart_dout,
  output logic                 cart_doe,
  output logic [CHIP_AW-1:0]   ram_addr,
  output logic [NUM_CHIPS-1:0] ram_ce_n,
  output logic                 ram_oe_n,
  output logic                 ram_we_n,
  output logic [DW-1:0]        ram_dq_out,
  output logic                 ram_dq_oe,
  input  logic [DW-1:0]        ram_dq_in,
  output logic                 load_active,
  output logic                 run_active
);

  logic                 hirom;
  logic [IMG_AW-1:0]    c_img;
  logic                 c_in_range;
  logic                 c_read, c_hit;
  logic                 l_acc, l_wr, l_rd;
  logic [NUM_CHIPS-1:0] c_sel, l_sel;
  logic [CHIP_AW-1:0]   c_low, l_low;

  cmap_owner_seq #(.GAP_CYCLES(GAP_CYCLES)) u_owner (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_run     (cfg_run),
    .cfg_hirom   (cfg_hirom),
    .load_active (load_active),
    .run_active  (run_active),
    .hirom       (hirom)
  );

  cmap_xlate #(.CART_AW(CART_AW), .IMG_AW(IMG_AW)) u_xlate (
    .cart_addr (cart_addr),
    .hirom     (hirom),
    .img_addr  (c_img),
    .in_range  (c_in_range)
  );

  // console side: reads only, never a write
  assign c_read = run_active && !cart_cs_n && !cart_rd_n && cart_wr_n;
  assign c_hit  = c_read && c_in_range;

  // loader side: only while it owns the memory
  assign l_wr  = load_active && ld_we;
  assign l_rd  = load_active && ld_re && !ld_we;
  assign l_acc = l_wr || l_rd;

  cmap_chip_dec #(.IMG_AW(IMG_AW), .CHIP_AW(CHIP_AW)) u_cdec (
    .en  (c_hit),
    .lin (c_img),
    .sel (c_sel),
    .low (c_low)
  );

  cmap_chip_dec #(.IMG_AW(IMG_AW), .CHIP_AW(CHIP_AW)) u_ldec (
    .en  (l_acc),
    .lin (ld_addr),
    .sel (l_sel),
    .low (l_low)
  );

  assign ram_ce_n   = ~(c_sel | l_sel);
  assign ram_addr   = run_active ? c_low : l_low;
  assign ram_oe_n   = !(c_hit || l_rd);
  assign ram_we_n   = !l_wr;
  assign ram_dq_oe  = l_wr;
  assign ram_dq_out = ld_wdata;
  assign cart_doe   = c_hit;
  assign cart_dout  = c_hit ? ram_dq_in : '0;
  assign ld_rdata   = l_rd ? ram_dq_in : '0;

  AST_NO_CART_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && !cart_wr_n) |-> (ram_we_n && !cart_doe)); // R5
  AST_WE_ONLY_LOADER: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> load_active); // R8
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(cart_doe && ram_dq_oe)); // R6
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_active && !run_active) |-> (&ram_ce_n && !cart_doe && !ram_dq_oe)); // R6
  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ram_ce_n)); // R2
  AST_DOE_HAS_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    cart_doe |-> (!ram_oe_n && !(&ram_ce_n))); // R4

endmodule

// File: tb/sim_cart_rom_mapper.sv
`timescale 1ns/1ps
module sim_cart_rom_mapper;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_run, cfg_hirom;
  logic [18:0] ld_addr;
  logic [7:0]  ld_wdata, ld_rdata;
  logic        ld_we, ld_re;
  logic [21:0] cart_addr;
  logic        cart_cs_n, cart_rd_n, cart_wr_n;
  logic [7:0]  cart_dout;
  logic        cart_doe;
  logic [16:0] ram_addr;
  logic [3:0]  ram_ce_n;
  logic        ram_oe_n, ram_we_n, ram_dq_oe;
  logic [7:0]  ram_dq_out, ram_dq_in;
  logic        load_active, run_active;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  cart_rom_mapper u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_run(cfg_run), .cfg_hirom(cfg_hirom),
    .ld_addr(ld_addr), .ld_wdata(ld_wdata), .ld_we(ld_we), .ld_re(ld_re), .ld_rdata(ld_rdata),
    .cart_addr(cart_addr), .cart_cs_n(cart_cs_n), .cart_rd_n(cart_rd_n), .cart_wr_n(cart_wr_n),
    .cart_dout(cart_dout), .cart_doe(cart_doe),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in),
    .load_active(load_active), .run_active(run_active)
  );

  // SRAM model: content is a function of chip and address
  function automatic logic [7:0] mem_byte(int chip, logic [16:0] a);
    return 8'(chip * 53) ^ a[7:0] ^ a[15:8] ^ {7'b0, a[16]};
  endfunction

  always_comb begin
    ram_dq_in = 8'h00;
    for (int i = 0; i < 4; i++)
      if (!ram_ce_n[i]) ram_dq_in = mem_byte(i, ram_addr);
  end

  typedef struct {
    string       tag;
    logic        doe;
    logic [7:0]  dout;
    logic [3:0]  ce_n;
    logic [16:0] addr;
    logic        we_n;
  } exp_t;

  exp_t sb_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares console-side results half a cycle after the driver
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      logic ok;
      e = sb_q.pop_front();
      ok = (cart_doe === e.doe) && (ram_ce_n === e.ce_n) && (ram_we_n === e.we_n);
      if (e.doe) ok = ok && (cart_dout === e.dout) && (ram_addr === e.addr);
      n_tests++;
      if (!ok) begin
        n_fail++;
        $display("FAIL %s actual doe=%b dout=%h ce_n=%b addr=%h we_n=%b expected doe=%b dout=%h ce_n=%b addr=%h we_n=%b",
                 e.tag, cart_doe, cart_dout, ram_ce_n, ram_addr, ram_we_n,
                 e.doe, e.dout, e.ce_n, e.addr, e.we_n);
      end
    end
  end

  // driver: console access with expectation pushed to the scoreboard
  task automatic cart_access(string tag, logic [21:0] a, logic hi, logic cs_n, logic rd_n, logic wr_n);
    exp_t e;
    logic [21:0] lin;
    int chip;
    @(posedge clk); #1;
    cart_addr = a; cart_cs_n = cs_n; cart_rd_n = rd_n; cart_wr_n = wr_n;
    lin = hi ? a : {1'b0, a[21:16], a[14:0]};
    e.tag  = tag;
    e.we_n = 1'b1;
    e.doe  = !cs_n && !rd_n && wr_n && (lin < 22'h080000);
    chip   = int'(lin[18:17]);
    e.addr = lin[16:0];
    e.ce_n = e.doe ? ~(4'b0001 << chip) : 4'hF;
    e.dout = mem_byte(chip, lin[16:0]);
    sb_q.push_back(e);
    @(negedge clk); #1;
    cart_cs_n = 1'b1; cart_rd_n = 1'b1; cart_wr_n = 1'b1;
  endtask

  task automatic cfg_write(logic run, logic hi);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_run = run; cfg_hirom = hi;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic check_gap(string tag);
    check({tag, " load_active"}, 32'(load_active), 32'd0);
    check({tag, " run_active"},  32'(run_active),  32'd0);
    check({tag, " ce_n"},        32'(ram_ce_n),    32'hF);
    check({tag, " doe"},         32'(cart_doe),    32'd0);
    check({tag, " dq_oe"},       32'(ram_dq_oe),   32'd0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #500000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_run = 0; cfg_hirom = 0;
    ld_addr = '0; ld_wdata = '0; ld_we = 0; ld_re = 0;
    cart_addr = '0; cart_cs_n = 1; cart_rd_n = 1; cart_wr_n = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 load_active", 32'(load_active), 32'd1);
    check("R1 run_active",  32'(run_active),  32'd0);
    check("R1 doe",         32'(cart_doe),    32'd0);
    check("R1 we_n",        32'(ram_we_n),    32'd1);
    check("R1 ce_n",        32'(ram_ce_n),    32'hF);

    // R8: loader write, console strobes active and ignored
    ld_addr = 19'h5_1234; ld_wdata = 8'hA5; ld_we = 1;
    cart_cs_n = 0; cart_rd_n = 0; cart_wr_n = 0; cart_addr = 22'h00_8000;
    #1;
    check("R8 we_n",   32'(ram_we_n),   32'd0);
    check("R8 ce_n",   32'(ram_ce_n),   32'b1011);
    check("R8 addr",   32'(ram_addr),   32'h1_1234);
    check("R8 dq_oe",  32'(ram_dq_oe),  32'd1);
    check("R8 dq_out", 32'(ram_dq_out), 32'hA5);
    check("R8 doe",    32'(cart_doe),   32'd0);
    cart_cs_n = 1; cart_rd_n = 1; cart_wr_n = 1;
    // R10: loader read
    ld_we = 0; ld_re = 1; ld_addr = 19'h7_00F0;
    #1;
    check("R10 oe_n",  32'(ram_oe_n), 32'd0);
    check("R10 rdata", 32'(ld_rdata), 32'(mem_byte(3, 17'h1_00F0)));
    ld_re = 0;

    // R6: switch to console, banked map; console strobes held during the write
    cart_cs_n = 0; cart_rd_n = 0; cart_addr = 22'h00_8000;
    cfg_write(1'b1, 1'b0);
    check_gap("R6 gap1");
    cfg_we = 1; cfg_run = 0; // R6: ignored during the gap
    @(posedge clk); #1;
    cfg_we = 0;
    check_gap("R6 gap2");
    @(posedge clk); #1;
    check("R6 run_active", 32'(run_active), 32'd1);
    cart_cs_n = 1; cart_rd_n = 1;

    // R2: banked reads
    cart_access("R2 first byte",  22'h00_8000, 0, 0, 0, 1);
    cart_access("R2 bank1",       22'h01_8123, 0, 0, 0, 1);
    cart_access("R2 bit15 clear", 22'h05_0ABC, 0, 0, 0, 1);
    cart_access("R2 last byte",   22'h0F_FFFF, 0, 0, 0, 1);
    // R4: beyond image, and ROM select idle
    cart_access("R4 banked oor",  22'h10_8000, 0, 0, 0, 1);
    cart_access("R4 cs idle",     22'h01_8123, 0, 1, 0, 1);
    // R5: console writes, alone and together with a read strobe
    cart_access("R5 write",       22'h00_8000, 0, 0, 1, 0);
    cart_access("R5 write+read",  22'h02_8000, 0, 0, 0, 0);
    // R8: loader strobe ignored under console ownership
    @(posedge clk); #1;
    ld_we = 1; ld_addr = 19'h0_0010;
    #1;
    check("R8 run we_n",  32'(ram_we_n),  32'd1);
    check("R8 run dq_oe", 32'(ram_dq_oe), 32'd0);
    ld_we = 0;

    // R9: map write under console ownership does nothing
    cfg_write(1'b1, 1'b1);
    cart_access("R9 still banked", 22'h01_0000, 0, 0, 0, 1);

    // R7: back to the loader
    cfg_write(1'b0, 1'b1);
    check_gap("R7 gap1");
    @(posedge clk); #1;
    check_gap("R7 gap2");
    @(posedge clk); #1;
    check("R7 load_active", 32'(load_active), 32'd1);

    // R3: flat map
    cfg_write(1'b1, 1'b1);
    repeat (2) @(posedge clk);
    #1;
    check("R3 run_active", 32'(run_active), 32'd1);
    cart_access("R3 flat low",   22'h01_0000, 1, 0, 0, 1);
    cart_access("R3 flat mid",   22'h05_4321, 1, 0, 0, 1);
    cart_access("R3 flat last",  22'h07_FFFF, 1, 0, 0, 1);
    cart_access("R4 flat oor",   22'h08_0000, 1, 0, 0, 1);
    cart_access("R4 flat top",   22'h3F_FFFF, 1, 0, 0, 1);
    cart_access("R5 flat write", 22'h01_0000, 1, 0, 1, 0);

    repeat (3) @(posedge clk);
    check("R2 scoreboard drained", 32'(sb_q.size()), 32'd0);
    finish_run();
  end

endmodule